// File: doc/BRIEF.md
# Conflict-Only Instruction Cache

This block sits beside a program-memory bus that is shared between instruction fetches and data transfers. When a fetch and a data transfer want the bus in the same cycle, the block looks the fetch address up in a small store of 48-bit instruction words. On a hit, the word comes from the store, the data transfer takes the bus, and both complete in that cycle. On a miss, the fetch is stalled for one cycle while the data transfer uses the bus. The next cycle the bus fetches the instruction, and the word is delivered and written into the store. A tight loop therefore pays for each conflicting fetch once, and runs without stalls from the second pass on.

Fetches that meet no data transfer go straight to the bus. They neither look up nor fill the store. The store holds 32 words as 16 sets of 2 ways, with a least-recently-used choice of victim in each set. A flush input invalidates every entry at once.

The fetch request is a valid/ready stream. The requester raises `fetch_valid` with `fetch_addr` and must hold both unchanged until it sees `fetch_ready` high at a clock edge. The instruction output has no back-pressure: `insn_valid` marks the cycle in which `insn_word` carries the accepted fetch's instruction, and the consumer must take it in that cycle. The memory behind the bus answers `bus_rdata` in the same cycle as `bus_fetch`.

Top module: `confl_icache`

## Requirements
- R1: Out of reset every entry is invalid. The first fetch that meets a data transfer misses and raises `stall`. During reset `insn_valid`, `hit` and `stall` are 0.
- R2: A fetch with `data_pending` low gets the bus in the same cycle: `bus_fetch`=1, `bus_addr`=`fetch_addr`, `fetch_ready`=1, `insn_valid`=1, `insn_word`=`bus_rdata`, `hit`=0, `data_grant`=0. Such a fetch does not fill the store, so a later conflicting fetch of the same address still misses.
- R3: A conflicting fetch that misses gives `stall`=1, `fetch_ready`=0, `bus_fetch`=0 and `data_grant`=1 in that cycle. In the next cycle (the refill) `bus_fetch`=1 at the held address, `data_grant`=0 whatever `data_pending` is, and `fetch_ready`=1 and `insn_valid`=1 with `insn_word`=`bus_rdata`.
- R4: After a refill, a conflicting fetch of the same address hits. In that cycle `hit`=1, `fetch_ready`=1, `insn_valid`=1, `bus_fetch`=0 and `data_grant`=1, and `insn_word` is the stored 48-bit word.
- R5: Two addresses that share the low 4 address bits (the set index) can be resident together, one per way.
- R6: A refill into a full set evicts the way whose last hit or fill is older. A hit counts as a use.
- R7: `flush` high for one cycle invalidates all entries. No fetch hits in the following cycle or later until it is refilled.
- R8: With `fetch_valid` low and no refill due, `fetch_ready`, `insn_valid`, `bus_fetch` and `hit` are 0, and `data_grant` equals `data_pending`.
- R9: A refill cycle with `flush` high still delivers the instruction, but it does not store it. The next conflicting fetch of that address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Fetch accepted this cycle |
| fetch_addr | input | 24 | Instruction word address |
| data_pending | input | 1 | A data transfer wants the shared bus |
| data_grant | output | 1 | Data transfer owns the bus this cycle |
| bus_fetch | output | 1 | Instruction read on the bus this cycle |
| bus_addr | output | 24 | Address of the bus instruction read |
| bus_rdata | input | 48 | Instruction word returned by the bus |
| insn_valid | output | 1 | `insn_word` is valid |
| insn_word | output | 48 | Delivered instruction |
| hit | output | 1 | Instruction served from the store |
| stall | output | 1 | Conflicting fetch missed; refill next cycle |

## Verification
Plain fetches, hits and stall indications settle in the same cycle as their inputs. The refill comes exactly one cycle after a stall, and a flush takes effect from the cycle after it is raised. The bench therefore drives each step just after a falling edge and samples all outputs 1 ns later, before the next rising edge. Stored results are probed with later fetches rather than by looking inside the design. Every instruction word is checked against an address-derived pattern that the bench's bus model returns.

// File: rtl/confl_icache_pkg.sv
package confl_icache_pkg;
  localparam int INSN_W = 48;

  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_REFILL = 1'b1
  } icc_state_e;
endpackage

// File: rtl/icc_tag_store.sv
module icc_tag_store #(
  parameter int ADDR_W = 24,
  parameter int SETS   = 16,
  parameter int WAYS   = 2,
  parameter int INSN_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              wr_en,
  input  logic [WAYS-1:0]   wr_way_oh,
  input  logic [INSN_W-1:0] wr_data,
  output logic [WAYS-1:0]   way_hit,
  output logic [WAYS-1:0]   way_valid,
  output logic [INSN_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag_in;
  logic [INSN_W-1:0] way_word [WAYS];

  assign set_idx = look_addr[IDX_W-1:0];
  assign tag_in  = look_addr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [INSN_W-1:0] dat_q [SETS];
    logic              wr_this;

    assign wr_this = wr_en && wr_way_oh[w] && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld_q <= '0;
      else if (flush)   vld_q <= '0;
      else if (wr_this) vld_q[set_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_this) begin
        tag_q[set_idx] <= tag_in;
        dat_q[set_idx] <= wr_data;
      end
    end

    assign way_valid[w] = vld_q[set_idx];
    assign way_hit[w]   = vld_q[set_idx] && (tag_q[set_idx] == tag_in);
    assign way_word[w]  = way_hit[w] ? dat_q[set_idx] : '0;
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WAYS; w++) rd_data = rd_data | way_word[w];
  end
endmodule

// File: rtl/icc_lru.sv
module icc_lru #(
  parameter int SETS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] set_idx,
  input  logic                    upd_en,
  input  logic                    upd_way,
  output logic                    victim_way
);
  logic [SETS-1:0] older_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      older_q <= '0;
    else if (upd_en) older_q[set_idx] <= ~upd_way;
  end

  assign victim_way = older_q[set_idx];
endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import confl_icache_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              data_pending,
  input  logic              cache_hit,
  output logic              fetch_ready,
  output logic              stall,
  output logic              bus_fetch,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              data_grant,
  output logic              serve_hit,
  output logic              refill
);
  icc_state_e        state_q;
  logic [ADDR_W-1:0] held_q;
  logic              conflict;

  assign refill      = (state_q == ST_REFILL);
  assign conflict    = !refill && fetch_valid && data_pending;
  assign serve_hit   = conflict && cache_hit;
  assign stall       = conflict && !cache_hit;
  assign bus_fetch   = refill || (!refill && fetch_valid && !data_pending);
  assign bus_addr    = refill ? held_q : fetch_addr;
  assign data_grant  = data_pending && !bus_fetch;
  assign fetch_ready = bus_fetch || serve_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOOKUP;
      held_q  <= '0;
    end else if (stall) begin
      state_q <= ST_REFILL;
      held_q  <= fetch_addr;
    end else begin
      state_q <= ST_LOOKUP;
    end
  end
endmodule

// File: rtl/confl_icache.sv
module confl_icache
  import confl_icache_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              data_pending,
  output logic              data_grant,
  output logic              bus_fetch,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [INSN_W-1:0] bus_rdata,
  output logic              insn_valid,
  output logic [INSN_W-1:0] insn_word,
  output logic              hit,
  output logic              stall
);
  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);

  logic [WAYS-1:0]   way_hit, way_valid, fill_oh;
  logic [INSN_W-1:0] store_word;
  logic              serve_hit, refill, lru_victim, fill_en, lru_upd, lru_way;

  icc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .data_pending(data_pending), .cache_hit(|way_hit), .fetch_ready(fetch_ready),
    .stall(stall), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
    .data_grant(data_grant), .serve_hit(serve_hit), .refill(refill)
  );

  // victim: first empty way, otherwise the older one
  always_comb begin
    if (!way_valid[0])      fill_oh = 2'b01;
    else if (!way_valid[1]) fill_oh = 2'b10;
    else                    fill_oh = lru_victim ? 2'b10 : 2'b01;
  end

  assign fill_en = refill && !flush;
  assign lru_upd = serve_hit || fill_en;
  assign lru_way = serve_hit ? way_hit[1] : fill_oh[1];

  icc_tag_store #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .INSN_W(INSN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .look_addr(bus_addr),
    .wr_en(fill_en), .wr_way_oh(fill_oh), .wr_data(bus_rdata),
    .way_hit(way_hit), .way_valid(way_valid), .rd_data(store_word)
  );

  icc_lru #(.SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n), .set_idx(bus_addr[IDX_W-1:0]),
    .upd_en(lru_upd), .upd_way(lru_way), .victim_way(lru_victim)
  );

  assign hit        = serve_hit;
  assign insn_valid = fetch_ready;
  assign insn_word  = serve_hit ? store_word : bus_rdata;
endmodule

// File: rtl/confl_icache_chk.sv
module confl_icache_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              data_pending,
  input logic              data_grant,
  input logic              fetch_ready,
  input logic              bus_fetch,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              insn_valid,
  input logic              hit,
  input logic              stall
);
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!fetch_ready && !bus_fetch && data_grant));

  assert_refill_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (bus_fetch && insn_valid && !hit && !data_grant && bus_addr == $past(fetch_addr)));

  assert_hit_shares_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (!bus_fetch && fetch_ready && data_grant && insn_valid));

  assert_plain_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !data_pending && !$past(stall)) |-> (bus_fetch && !hit && !stall && bus_addr == fetch_addr));

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !$past(stall)) |-> (!insn_valid && !bus_fetch && (data_grant == data_pending)));
endmodule

bind confl_icache confl_icache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_confl_icache.sv
`timescale 1ns/1ps
module sim_confl_icache;
  localparam int AW = 24;

  typedef struct packed {
    logic          fv;
    logic          dp;
    logic [AW-1:0] addr;
    logic          rdy;
    logic          hit;
    logic          stl;
    logic          busf;
    logic          grant;
  } vec_t;

  // fv dp addr | rdy hit stall busf grant
  localparam vec_t VEC [21] = '{
    '{1'b1,1'b0,24'h10, 1'b1,1'b0,1'b0,1'b1,1'b0},  // R2 plain
    '{1'b1,1'b1,24'h10, 1'b0,1'b0,1'b1,1'b0,1'b1},  // R2 not filled -> R3 miss
    '{1'b1,1'b1,24'h10, 1'b1,1'b0,1'b0,1'b1,1'b0},  // R3 refill
    '{1'b1,1'b1,24'h10, 1'b1,1'b1,1'b0,1'b0,1'b1},  // R4 hit
    '{1'b1,1'b1,24'h20, 1'b0,1'b0,1'b1,1'b0,1'b1},  // R5 miss same set
    '{1'b1,1'b1,24'h20, 1'b1,1'b0,1'b0,1'b1,1'b0},  // R5 refill
    '{1'b1,1'b1,24'h20, 1'b1,1'b1,1'b0,1'b0,1'b1},  // R5 hit
    '{1'b1,1'b1,24'h10, 1'b1,1'b1,1'b0,1'b0,1'b1},  // R5 both resident
    '{1'b1,1'b1,24'h30, 1'b0,1'b0,1'b1,1'b0,1'b1},  // R6 third miss
    '{1'b1,1'b1,24'h30, 1'b1,1'b0,1'b0,1'b1,1'b0},  // R6 refill evicts 0x20
    '{1'b1,1'b1,24'h10, 1'b1,1'b1,1'b0,1'b0,1'b1},  // R6 recent kept
    '{1'b1,1'b1,24'h20, 1'b0,1'b0,1'b1,1'b0,1'b1},  // R6 evicted
    '{1'b1,1'b1,24'h20, 1'b1,1'b0,1'b0,1'b1,1'b0},  // R6 refill evicts 0x30
    '{1'b1,1'b1,24'h30, 1'b0,1'b0,1'b1,1'b0,1'b1},  // R6 0x30 gone
    '{1'b1,1'b1,24'h30, 1'b1,1'b0,1'b0,1'b1,1'b0},  // R3 refill
    '{1'b0,1'b1,24'h40, 1'b0,1'b0,1'b0,1'b0,1'b1},  // R8 idle, data only
    '{1'b0,1'b0,24'h40, 1'b0,1'b0,1'b0,1'b0,1'b0},  // R8 quiet
    '{1'b1,1'b1,24'h05, 1'b0,1'b0,1'b1,1'b0,1'b1},  // R3 other set
    '{1'b1,1'b0,24'h05, 1'b1,1'b0,1'b0,1'b1,1'b0},  // R3 refill, data gone
    '{1'b1,1'b1,24'h05, 1'b1,1'b1,1'b0,1'b0,1'b1},  // R4 hit
    '{1'b1,1'b0,24'h05, 1'b1,1'b0,1'b0,1'b1,1'b0}   // R2 no lookup
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          fetch_valid = 1'b0;
  logic          fetch_ready;
  logic [AW-1:0] fetch_addr = '0;
  logic          data_pending = 1'b0;
  logic          data_grant, bus_fetch, insn_valid, hit, stall;
  logic [AW-1:0] bus_addr;
  logic [47:0]   bus_rdata, insn_word;
  int            checks = 0;
  int            failures = 0;

  always #2.5 clk = ~clk;

  function automatic logic [47:0] mem_word(input logic [AW-1:0] a);
    return {8'hC3, a, ~a[15:0]};
  endfunction

  assign bus_rdata = mem_word(bus_addr);

  confl_icache u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .data_pending(data_pending),
    .data_grant(data_grant), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .insn_valid(insn_valid), .insn_word(insn_word),
    .hit(hit), .stall(stall)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input vec_t v, input logic fl, input string req);
    @(negedge clk);
    fetch_valid  = v.fv;
    data_pending = v.dp;
    fetch_addr   = v.addr;
    flush        = fl;
    #1;
    chk(req, "ready", 64'(fetch_ready), 64'(v.rdy));
    chk(req, "hit",   64'(hit),         64'(v.hit));
    chk(req, "stall", 64'(stall),       64'(v.stl));
    chk(req, "busf",  64'(bus_fetch),   64'(v.busf));
    chk(req, "grant", 64'(data_grant),  64'(v.grant));
    chk(req, "ivld",  64'(insn_valid),  64'(v.rdy));
    if (v.rdy) chk(req, "insn", 64'(insn_word), 64'(mem_word(v.addr)));
    if (v.busf) chk(req, "baddr", 64'(bus_addr), 64'(v.addr));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "ivld in reset", 64'(insn_valid), 64'd0);
    chk("R1", "hit in reset", 64'(hit), 64'd0);
    chk("R1", "stall in reset", 64'(stall), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first conflict misses
    step('{1'b1,1'b1,24'h0A, 1'b0,1'b0,1'b1,1'b0,1'b1}, 1'b0, "R1");
    step('{1'b1,1'b1,24'h0A, 1'b1,1'b0,1'b0,1'b1,1'b0}, 1'b0, "R1");

    for (int i = 0; i < 21; i++) step(VEC[i], 1'b0, "R2-table");

    // R7: flush with no fetch, then 0x05 and 0x10 miss
    step('{1'b0,1'b0,24'h00, 1'b0,1'b0,1'b0,1'b0,1'b0}, 1'b1, "R7");
    step('{1'b1,1'b1,24'h05, 1'b0,1'b0,1'b1,1'b0,1'b1}, 1'b0, "R7");
    step('{1'b1,1'b1,24'h05, 1'b1,1'b0,1'b0,1'b1,1'b0}, 1'b0, "R7");
    step('{1'b1,1'b1,24'h10, 1'b0,1'b0,1'b1,1'b0,1'b1}, 1'b0, "R7");
    step('{1'b1,1'b1,24'h10, 1'b1,1'b0,1'b0,1'b1,1'b0}, 1'b0, "R7");

    // R9: flush during refill delivers but does not store
    step('{1'b1,1'b1,24'h07, 1'b0,1'b0,1'b1,1'b0,1'b1}, 1'b0, "R9");
    step('{1'b1,1'b1,24'h07, 1'b1,1'b0,1'b0,1'b1,1'b0}, 1'b1, "R9");
    step('{1'b1,1'b1,24'h07, 1'b0,1'b0,1'b1,1'b0,1'b1}, 1'b0, "R9");
    step('{1'b1,1'b1,24'h07, 1'b1,1'b0,1'b0,1'b1,1'b0}, 1'b0, "R9");
    step('{1'b1,1'b1,24'h07, 1'b1,1'b1,1'b0,1'b0,1'b1}, 1'b0, "R9");

    @(negedge clk);
    fetch_valid = 1'b0;
    data_pending = 1'b0;
    summary();
  end
endmodule